// File: doc/BRIEF.md
# Two-Layer Alpha Blend Stage

This block is one link of a cascadable plane combiner. Each clock it can accept one top-layer pixel from a pipe and one bottom-layer pixel, which comes from the stage below. When no lower stage is attached, a programmable background colour stands in for the bottom pixel. It produces one composited pixel with RGB and alpha. Several stages can be chained, each feeding the bottom input of the next.

A layer mode selects what the stage contributes:
- it can pass the bottom pixel through untouched;
- it can forward the top pixel untouched;
- it can scale the top pixel by alpha over black;
- it can composite top over bottom.

The effective alpha has three possible sources:
- the pixel's own alpha;
- that alpha multiplied by a programmable gain;
- a programmable plane alpha.

A premultiplied flag says the top colour already carries its alpha. With that flag set, the top colour is added rather than scaled.

All configuration inputs are shadowed. They act only from a frame-start pulse onward, so a frame never mixes two settings. The datapath is a two-register pipeline qualified by a valid bit.

Top module: `alpha_blend_stage`

## Requirements
- R1: During reset and right after its release, out_valid, out_rgb and out_alpha are all zero.
- R2: A pixel accepted with in_valid high appears with out_valid high exactly two clock edges later. A cycle with in_valid low yields out_valid low two edges later.
- R3: Layer mode code 0 (bypass) outputs the bottom pixel's RGB and alpha unchanged. If a lower stage is absent, the bottom pixel is the background.
- R4: Layer mode code 1 (top passthrough) outputs the top pixel's RGB and alpha unchanged.
- R5: Layer mode code 2 (top only) outputs each channel as mul(top, a), or the top channel itself when premultiplied. The output alpha is a.
- R6: Alpha source code 0 uses the top pixel alpha. Code 1 uses mul(pixel alpha, gain). Codes 2 and 3 use the plane alpha and ignore the pixel alpha.
- R7: Layer mode code 3 (blend) outputs min(255, T + mul(bottom, 255-a)) per channel, where T = mul(top, a) when not premultiplied and T = top when premultiplied. The output alpha is min(255, a + mul(bottom alpha, 255-a)).
- R8: While the lower-stage-connected setting is 0, the bottom pixel is the background colour with alpha 255. The bottom inputs are then ignored.
- R9: Configuration inputs take effect only in a cycle with frame_start high, starting with the pixel of that same cycle. Changes at any other time have no effect on output.
- R10: mul(x, y) = (x*y + 128) >> 8 on 8-bit unsigned values with 255 meaning 1.0. So mul(200, 255) = 199 and mul(x, 0) = 0.
- R11: RGB buses pack red in bits [23:16], green in [15:8] and blue in [7:0]. Each channel is computed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Loads the configuration shadow |
| cfg_mode | input | 2 | Layer mode: 0 bypass, 1 top passthrough, 2 top only, 3 blend |
| cfg_alpha_src | input | 2 | Alpha source: 0 pixel, 1 pixel times gain, 2/3 plane |
| cfg_plane_alpha | input | AW | Plane alpha |
| cfg_gain | input | AW | Gain applied to pixel alpha |
| cfg_premul | input | 1 | Top colour is premultiplied |
| cfg_bot_connected | input | 1 | A lower stage drives the bottom input |
| cfg_bg_rgb | input | 3*CW | Background colour |
| in_valid | input | 1 | Input pixel qualifier |
| top_rgb | input | 3*CW | Top-layer colour |
| top_alpha | input | AW | Top-layer alpha |
| bot_rgb | input | 3*CW | Bottom-layer colour |
| bot_alpha | input | AW | Bottom-layer alpha |
| out_valid | output | 1 | Output pixel qualifier |
| out_rgb | output | 3*CW | Composited colour |
| out_alpha | output | AW | Composited alpha |

## Verification
A frame-start pulse and a valid pixel can arrive in the same cycle. That pixel must already use the newly presented settings, while every earlier pixel in the pipe keeps the old ones. The bench raises frame_start together with a pixel right after changing the mode. It also changes settings without a pulse. A reference shadow in the bench, updated only on the pulse, predicts each output, and every clock is compared against it.

// File: rtl/blend_pkg.sv
package blend_pkg;
  typedef enum logic [1:0] {
    LM_BYPASS   = 2'd0,
    LM_TOP_PASS = 2'd1,
    LM_TOP_ONLY = 2'd2,
    LM_BLEND    = 2'd3
  } layer_mode_e;

  typedef enum logic [1:0] {
    AS_PIXEL  = 2'd0,
    AS_GAINED = 2'd1,
    AS_PLANE  = 2'd2,
    AS_PLANE2 = 2'd3
  } alpha_src_e;
endpackage

// File: rtl/blend_cfg_shadow.sv
module blend_cfg_shadow
  import blend_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_alpha_src,
  input  logic [AW-1:0]   cfg_plane_alpha,
  input  logic [AW-1:0]   cfg_gain,
  input  logic            cfg_premul,
  input  logic            cfg_bot_connected,
  input  logic [3*CW-1:0] cfg_bg_rgb,
  output logic [1:0]      act_mode,
  output logic [1:0]      act_alpha_src,
  output logic [AW-1:0]   act_plane_alpha,
  output logic [AW-1:0]   act_gain,
  output logic            act_premul,
  output logic            act_bot_connected,
  output logic [3*CW-1:0] act_bg_rgb
);
  logic [1:0]      sh_mode,  sh_mode_nxt;
  logic [1:0]      sh_src,   sh_src_nxt;
  logic [AW-1:0]   sh_pa,    sh_pa_nxt;
  logic [AW-1:0]   sh_gain,  sh_gain_nxt;
  logic            sh_pm,    sh_pm_nxt;
  logic            sh_bc,    sh_bc_nxt;
  logic [3*CW-1:0] sh_bg,    sh_bg_nxt;

  // next state: shadow loads on the frame-start pulse only
  always_comb begin
    sh_mode_nxt = sh_mode;
    sh_src_nxt  = sh_src;
    sh_pa_nxt   = sh_pa;
    sh_gain_nxt = sh_gain;
    sh_pm_nxt   = sh_pm;
    sh_bc_nxt   = sh_bc;
    sh_bg_nxt   = sh_bg;
    if (frame_start) begin
      sh_mode_nxt = cfg_mode;
      sh_src_nxt  = cfg_alpha_src;
      sh_pa_nxt   = cfg_plane_alpha;
      sh_gain_nxt = cfg_gain;
      sh_pm_nxt   = cfg_premul;
      sh_bc_nxt   = cfg_bot_connected;
      sh_bg_nxt   = cfg_bg_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode <= LM_BYPASS;
      sh_src  <= AS_PIXEL;
      sh_pa   <= '1;
      sh_gain <= '1;
      sh_pm   <= 1'b0;
      sh_bc   <= 1'b1;
      sh_bg   <= '0;
    end else begin
      sh_mode <= sh_mode_nxt;
      sh_src  <= sh_src_nxt;
      sh_pa   <= sh_pa_nxt;
      sh_gain <= sh_gain_nxt;
      sh_pm   <= sh_pm_nxt;
      sh_bc   <= sh_bc_nxt;
      sh_bg   <= sh_bg_nxt;
    end
  end

  // the pixel that rides with the pulse already sees the new settings
  always_comb begin
    act_mode          = frame_start ? cfg_mode          : sh_mode;
    act_alpha_src     = frame_start ? cfg_alpha_src     : sh_src;
    act_plane_alpha   = frame_start ? cfg_plane_alpha   : sh_pa;
    act_gain          = frame_start ? cfg_gain          : sh_gain;
    act_premul        = frame_start ? cfg_premul        : sh_pm;
    act_bot_connected = frame_start ? cfg_bot_connected : sh_bc;
    act_bg_rgb        = frame_start ? cfg_bg_rgb        : sh_bg;
  end

  // R9: without a pulse the active settings must not move
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (frame_start || ($stable(act_mode) && $stable(act_alpha_src)
                      && $stable(act_premul) && $stable(act_bot_connected))));
endmodule

// File: rtl/blend_alpha_sel.sv
module blend_alpha_sel
  import blend_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3*CW-1:0] top_rgb,
  input  logic [AW-1:0]   top_alpha,
  input  logic [3*CW-1:0] bot_rgb,
  input  logic [AW-1:0]   bot_alpha,
  input  logic [1:0]      act_mode,
  input  logic [1:0]      act_alpha_src,
  input  logic [AW-1:0]   act_plane_alpha,
  input  logic [AW-1:0]   act_gain,
  input  logic            act_premul,
  input  logic            act_bot_connected,
  input  logic [3*CW-1:0] act_bg_rgb,
  output logic            s1_valid,
  output logic [1:0]      s1_mode,
  output logic            s1_premul,
  output logic [AW-1:0]   s1_alpha,
  output logic [3*CW-1:0] s1_top_rgb,
  output logic [AW-1:0]   s1_top_alpha,
  output logic [3*CW-1:0] s1_bot_rgb,
  output logic [AW-1:0]   s1_bot_alpha
);
  localparam int PW = 2 * AW;
  localparam logic [PW-1:0] HALF = PW'(1) << (AW - 1);

  logic [PW-1:0]   gain_prod;
  logic [AW-1:0]   eff_alpha;
  logic [3*CW-1:0] sel_bot_rgb;
  logic [AW-1:0]   sel_bot_alpha;

  logic            valid_nxt;
  logic [1:0]      mode_nxt;
  logic            premul_nxt;
  logic [AW-1:0]   alpha_nxt;
  logic [3*CW-1:0] top_rgb_nxt, bot_rgb_nxt;
  logic [AW-1:0]   top_alpha_nxt, bot_alpha_nxt;

  always_comb begin
    gain_prod = {{AW{1'b0}}, top_alpha} * {{AW{1'b0}}, act_gain} + HALF;
    case (act_alpha_src)
      AS_PIXEL:  eff_alpha = top_alpha;
      AS_GAINED: eff_alpha = gain_prod[PW-1:AW];
      default:   eff_alpha = act_plane_alpha;
    endcase
    sel_bot_rgb   = act_bot_connected ? bot_rgb   : act_bg_rgb;
    sel_bot_alpha = act_bot_connected ? bot_alpha : '1;
  end

  // next state with clock enable on the data registers
  always_comb begin
    valid_nxt     = in_valid;
    mode_nxt      = s1_mode;
    premul_nxt    = s1_premul;
    alpha_nxt     = s1_alpha;
    top_rgb_nxt   = s1_top_rgb;
    top_alpha_nxt = s1_top_alpha;
    bot_rgb_nxt   = s1_bot_rgb;
    bot_alpha_nxt = s1_bot_alpha;
    if (in_valid) begin
      mode_nxt      = act_mode;
      premul_nxt    = act_premul;
      alpha_nxt     = eff_alpha;
      top_rgb_nxt   = top_rgb;
      top_alpha_nxt = top_alpha;
      bot_rgb_nxt   = sel_bot_rgb;
      bot_alpha_nxt = sel_bot_alpha;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid     <= 1'b0;
      s1_mode      <= LM_BYPASS;
      s1_premul    <= 1'b0;
      s1_alpha     <= '0;
      s1_top_rgb   <= '0;
      s1_top_alpha <= '0;
      s1_bot_rgb   <= '0;
      s1_bot_alpha <= '0;
    end else begin
      s1_valid     <= valid_nxt;
      s1_mode      <= mode_nxt;
      s1_premul    <= premul_nxt;
      s1_alpha     <= alpha_nxt;
      s1_top_rgb   <= top_rgb_nxt;
      s1_top_alpha <= top_alpha_nxt;
      s1_bot_rgb   <= bot_rgb_nxt;
      s1_bot_alpha <= bot_alpha_nxt;
    end
  end

  // R6: plane source ignores pixel alpha
  assert_plane_alpha_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act_alpha_src[1]) |=> (s1_alpha == $past(act_plane_alpha)));

  // R8: missing lower stage replaced by background, full alpha
  assert_bg_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !act_bot_connected) |=>
      (s1_bot_rgb == $past(act_bg_rgb) && s1_bot_alpha == {AW{1'b1}}));
endmodule

// File: rtl/blend_chan.sv
module blend_chan
  import blend_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic [CW-1:0] top_c,
  input  logic [CW-1:0] bot_c,
  input  logic [AW-1:0] alpha,
  input  logic [1:0]    mode,
  input  logic          premul,
  output logic [CW-1:0] res
);
  localparam int PW = CW + AW;
  localparam logic [PW-1:0] HALF = PW'(1) << (AW - 1);
  localparam logic [AW-1:0] ONE  = '1;
  localparam logic [CW:0]   CMAX = {1'b0, {CW{1'b1}}};

  logic [AW-1:0] inv;
  logic [PW-1:0] tp, bp;
  logic [CW-1:0] ts, bs, top_term;
  logic [CW:0]   sum;

  always_comb begin
    inv      = ONE - alpha;
    tp       = {{AW{1'b0}}, top_c} * {{CW{1'b0}}, alpha} + HALF;
    bp       = {{AW{1'b0}}, bot_c} * {{CW{1'b0}}, inv} + HALF;
    ts       = tp[PW-1:AW];
    bs       = bp[PW-1:AW];
    top_term = premul ? top_c : ts;
    sum      = {1'b0, top_term} + {1'b0, bs};
    case (mode)
      LM_BYPASS:   res = bot_c;
      LM_TOP_PASS: res = top_c;
      LM_TOP_ONLY: res = top_term;
      default:     res = (sum > CMAX) ? CMAX[CW-1:0] : sum[CW-1:0];
    endcase
  end
endmodule

// File: rtl/blend_mix.sv
module blend_mix
  import blend_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_valid,
  input  logic [1:0]      s1_mode,
  input  logic            s1_premul,
  input  logic [AW-1:0]   s1_alpha,
  input  logic [3*CW-1:0] s1_top_rgb,
  input  logic [AW-1:0]   s1_top_alpha,
  input  logic [3*CW-1:0] s1_bot_rgb,
  input  logic [AW-1:0]   s1_bot_alpha,
  output logic            out_valid,
  output logic [3*CW-1:0] out_rgb,
  output logic [AW-1:0]   out_alpha
);
  localparam int NCH = 3;

  logic [3*CW-1:0] mix_rgb;
  logic [AW-1:0]   comp_alpha;
  logic [AW-1:0]   mix_alpha;
  logic            valid_nxt;
  logic [3*CW-1:0] rgb_nxt;
  logic [AW-1:0]   alpha_nxt;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    blend_chan #(.CW(CW), .AW(AW)) u_chan (
      .top_c  (s1_top_rgb[c*CW +: CW]),
      .bot_c  (s1_bot_rgb[c*CW +: CW]),
      .alpha  (s1_alpha),
      .mode   (s1_mode),
      .premul (s1_premul),
      .res    (mix_rgb[c*CW +: CW])
    );
  end

  // coverage alpha: a + bottom*(1-a), i.e. premultiplied blend of a over bottom alpha
  blend_chan #(.CW(AW), .AW(AW)) u_alpha (
    .top_c  (s1_alpha),
    .bot_c  (s1_bot_alpha),
    .alpha  (s1_alpha),
    .mode   (LM_BLEND),
    .premul (1'b1),
    .res    (comp_alpha)
  );

  always_comb begin
    case (s1_mode)
      LM_BYPASS:   mix_alpha = s1_bot_alpha;
      LM_TOP_PASS: mix_alpha = s1_top_alpha;
      LM_TOP_ONLY: mix_alpha = s1_alpha;
      default:     mix_alpha = comp_alpha;
    endcase
  end

  always_comb begin
    valid_nxt = s1_valid;
    rgb_nxt   = s1_valid ? mix_rgb   : out_rgb;
    alpha_nxt = s1_valid ? mix_alpha : out_alpha;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_alpha <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_rgb   <= rgb_nxt;
      out_alpha <= alpha_nxt;
    end
  end

  // R3: bypass hands the bottom pixel on unchanged
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == LM_BYPASS) |=>
      (out_rgb == $past(s1_bot_rgb) && out_alpha == $past(s1_bot_alpha)));

  // R7: a premultiplied blend never darkens below the top colour
  assert_premul_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_premul && s1_mode == LM_BLEND) |=>
      (out_rgb[CW-1:0] >= $past(s1_top_rgb[CW-1:0])));
endmodule

// File: rtl/alpha_blend_stage.sv
module alpha_blend_stage
  import blend_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_alpha_src,
  input  logic [AW-1:0]   cfg_plane_alpha,
  input  logic [AW-1:0]   cfg_gain,
  input  logic            cfg_premul,
  input  logic            cfg_bot_connected,
  input  logic [3*CW-1:0] cfg_bg_rgb,
  input  logic            in_valid,
  input  logic [3*CW-1:0] top_rgb,
  input  logic [AW-1:0]   top_alpha,
  input  logic [3*CW-1:0] bot_rgb,
  input  logic [AW-1:0]   bot_alpha,
  output logic            out_valid,
  output logic [3*CW-1:0] out_rgb,
  output logic [AW-1:0]   out_alpha
);
  logic rst_q1, rst_sync_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  logic [1:0]      act_mode, act_alpha_src;
  logic [AW-1:0]   act_plane_alpha, act_gain;
  logic            act_premul, act_bot_connected;
  logic [3*CW-1:0] act_bg_rgb;

  logic            s1_valid, s1_premul;
  logic [1:0]      s1_mode;
  logic [AW-1:0]   s1_alpha, s1_top_alpha, s1_bot_alpha;
  logic [3*CW-1:0] s1_top_rgb, s1_bot_rgb;

  blend_cfg_shadow #(.CW(CW), .AW(AW)) u_cfg (
    .clk               (clk),
    .rst_n             (rst_sync_n),
    .frame_start       (frame_start),
    .cfg_mode          (cfg_mode),
    .cfg_alpha_src     (cfg_alpha_src),
    .cfg_plane_alpha   (cfg_plane_alpha),
    .cfg_gain          (cfg_gain),
    .cfg_premul        (cfg_premul),
    .cfg_bot_connected (cfg_bot_connected),
    .cfg_bg_rgb        (cfg_bg_rgb),
    .act_mode          (act_mode),
    .act_alpha_src     (act_alpha_src),
    .act_plane_alpha   (act_plane_alpha),
    .act_gain          (act_gain),
    .act_premul        (act_premul),
    .act_bot_connected (act_bot_connected),
    .act_bg_rgb        (act_bg_rgb)
  );

  blend_alpha_sel #(.CW(CW), .AW(AW)) u_sel (
    .clk               (clk),
    .rst_n             (rst_sync_n),
    .in_valid          (in_valid),
    .top_rgb           (top_rgb),
    .top_alpha         (top_alpha),
    .bot_rgb           (bot_rgb),
    .bot_alpha         (bot_alpha),
    .act_mode          (act_mode),
    .act_alpha_src     (act_alpha_src),
    .act_plane_alpha   (act_plane_alpha),
    .act_gain          (act_gain),
    .act_premul        (act_premul),
    .act_bot_connected (act_bot_connected),
    .act_bg_rgb        (act_bg_rgb),
    .s1_valid          (s1_valid),
    .s1_mode           (s1_mode),
    .s1_premul         (s1_premul),
    .s1_alpha          (s1_alpha),
    .s1_top_rgb        (s1_top_rgb),
    .s1_top_alpha      (s1_top_alpha),
    .s1_bot_rgb        (s1_bot_rgb),
    .s1_bot_alpha      (s1_bot_alpha)
  );

  blend_mix #(.CW(CW), .AW(AW)) u_mix (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .s1_valid     (s1_valid),
    .s1_mode      (s1_mode),
    .s1_premul    (s1_premul),
    .s1_alpha     (s1_alpha),
    .s1_top_rgb   (s1_top_rgb),
    .s1_top_alpha (s1_top_alpha),
    .s1_bot_rgb   (s1_bot_rgb),
    .s1_bot_alpha (s1_bot_alpha),
    .out_valid    (out_valid),
    .out_rgb      (out_rgb),
    .out_alpha    (out_alpha)
  );

  // cycles since reset release, saturating, so the latency check never looks before reset
  logic [1:0] age_q, age_nxt;
  always_comb age_nxt = (age_q == 2'd2) ? age_q : age_q + 2'd1;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) age_q <= 2'd0;
    else             age_q <= age_nxt;
  end

  // R2: two-edge latency of the valid qualifier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/alpha_blend_stage_test.sv
`timescale 1ns/1ps
module alpha_blend_stage_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [1:0]  cfg_mode, cfg_alpha_src;
  logic [7:0]  cfg_plane_alpha, cfg_gain;
  logic        cfg_premul, cfg_bot_connected;
  logic [23:0] cfg_bg_rgb;
  logic        in_valid;
  logic [23:0] top_rgb, bot_rgb;
  logic [7:0]  top_alpha, bot_alpha;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic [7:0]  out_alpha;

  always #2.5 clk = ~clk;

  alpha_blend_stage uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_mode(cfg_mode), .cfg_alpha_src(cfg_alpha_src),
    .cfg_plane_alpha(cfg_plane_alpha), .cfg_gain(cfg_gain),
    .cfg_premul(cfg_premul), .cfg_bot_connected(cfg_bot_connected),
    .cfg_bg_rgb(cfg_bg_rgb), .in_valid(in_valid),
    .top_rgb(top_rgb), .top_alpha(top_alpha),
    .bot_rgb(bot_rgb), .bot_alpha(bot_alpha),
    .out_valid(out_valid), .out_rgb(out_rgb), .out_alpha(out_alpha)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // programmed settings (what software presents) and model shadow
  int c_mode = 0, c_src = 0, c_pa = 255, c_g = 255, c_pm = 0, c_bc = 1;
  logic [23:0] c_bg = 24'h0;
  int s_mode = 0, s_src = 0, s_pa = 255, s_g = 255, s_pm = 0, s_bc = 1;
  logic [23:0] s_bg = 24'h0;

  bit          q_v[$];
  logic [23:0] q_rgb[$];
  logic [7:0]  q_a[$];
  string       q_tag[$];

  function automatic int rm(int x, int y);
    return (x * y + 128) >> 8;
  endfunction

  function automatic int sat(int x);
    return (x > 255) ? 255 : x;
  endfunction

  function automatic int chan(int m, int pm, int t, int b, int a);
    int tt;
    tt = pm ? t : rm(t, a);
    case (m)
      0: return b;
      1: return t;
      2: return tt;
      default: return sat(tt + rm(b, 255 - a));
    endcase
  endfunction

  task automatic compare_front();
    bit ev; logic [23:0] er; logic [7:0] ea; string tg;
    ev = q_v.pop_front(); er = q_rgb.pop_front(); ea = q_a.pop_front(); tg = q_tag.pop_front();
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL %s valid: actual %0b expected %0b", tg, out_valid, ev);
    end else if (ev && (out_rgb !== er || out_alpha !== ea)) begin
      errors++;
      $display("FAIL %s pixel: actual %06h/%02h expected %06h/%02h", tg, out_rgb, out_alpha, er, ea);
    end
  endtask

  task automatic step(input bit fs, input bit v, input logic [23:0] trgb, input logic [7:0] ta,
                      input logic [23:0] brgb, input logic [7:0] ba, input string tag);
    int a, bb_a, oa;
    logic [23:0] br, orgb;
    @(negedge clk);
    if (q_v.size() >= 2) compare_front();
    frame_start = fs; in_valid = v;
    top_rgb = trgb; top_alpha = ta; bot_rgb = brgb; bot_alpha = ba;
    cfg_mode = 2'(c_mode); cfg_alpha_src = 2'(c_src);
    cfg_plane_alpha = 8'(c_pa); cfg_gain = 8'(c_g);
    cfg_premul = c_pm[0]; cfg_bot_connected = c_bc[0]; cfg_bg_rgb = c_bg;
    if (fs) begin
      s_mode = c_mode; s_src = c_src; s_pa = c_pa; s_g = c_g;
      s_pm = c_pm; s_bc = c_bc; s_bg = c_bg;
    end
    br   = s_bc ? brgb : s_bg;
    bb_a = s_bc ? int'(ba) : 255;
    a    = (s_src == 0) ? int'(ta) : (s_src == 1) ? rm(ta, s_g) : s_pa;
    for (int c = 0; c < 3; c++)
      orgb[c*8 +: 8] = 8'(chan(s_mode, s_pm, trgb[c*8 +: 8], br[c*8 +: 8], a));
    case (s_mode)
      0: oa = bb_a;
      1: oa = ta;
      2: oa = a;
      default: oa = sat(a + rm(bb_a, 255 - a));
    endcase
    q_v.push_back(v); q_rgb.push_back(orgb); q_a.push_back(8'(oa)); q_tag.push_back(tag);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 24'h0, 8'h0, 24'h0, 8'h0, "R2");
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (out_valid !== 1'b0 || out_rgb !== 24'h0 || out_alpha !== 8'h0) begin
      errors++;
      $display("FAIL %s reset: actual %0b/%06h/%02h expected 0/000000/00", tag, out_valid, out_rgb, out_alpha);
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0;
    top_rgb = '0; top_alpha = '0; bot_rgb = '0; bot_alpha = '0;
    cfg_mode = '0; cfg_alpha_src = '0; cfg_plane_alpha = '1; cfg_gain = '1;
    cfg_premul = 1'b0; cfg_bot_connected = 1'b1; cfg_bg_rgb = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");

    // R3 default bypass, R2 bubbles
    step(0, 1, 24'h112233, 8'h40, 24'hA0B0C0, 8'h77, "R3");
    step(0, 0, 24'h445566, 8'h40, 24'h010203, 8'h11, "R2");
    step(0, 1, 24'hFFFFFF, 8'hFF, 24'h00FF80, 8'h00, "R3");

    // R9 setting change without a pulse is ignored
    c_mode = 1;
    step(0, 1, 24'h123456, 8'h9A, 24'h654321, 8'h22, "R9");
    // R9 pulse with pixel in the same cycle uses the new mode, R4
    step(1, 1, 24'h123456, 8'h9A, 24'h654321, 8'h22, "R9");
    step(0, 1, 24'hDEADBE, 8'h05, 24'h000000, 8'h00, "R4");

    // R5 top only, pixel alpha
    c_mode = 2; c_src = 0;
    step(1, 1, 24'hC86432, 8'h80, 24'hFFFFFF, 8'hFF, "R5");
    step(0, 1, 24'hC8C8C8, 8'hFF, 24'h0, 8'h0, "R10");
    step(0, 1, 24'hFFFFFF, 8'h00, 24'h0, 8'h0, "R10");
    c_pm = 1;
    step(1, 1, 24'h804020, 8'h10, 24'hFFFFFF, 8'hFF, "R5");

    // R7 blend, not premultiplied
    c_mode = 3; c_pm = 0;
    step(1, 1, 24'hFF0000, 8'h80, 24'h0000FF, 8'h80, "R7");
    step(0, 1, 24'h102030, 8'h00, 24'hAABBCC, 8'h40, "R7");
    step(0, 1, 24'h102030, 8'hFF, 24'hAABBCC, 8'h40, "R10");
    step(0, 0, 24'h0, 8'h0, 24'h0, 8'h0, "R2");
    // R6 gained and plane sources
    c_src = 1; c_g = 8'h80;
    step(1, 1, 24'hF0F0F0, 8'hC0, 24'h202020, 8'h10, "R6");
    c_src = 2; c_pa = 8'h33;
    step(1, 1, 24'hF0F0F0, 8'hC0, 24'h202020, 8'h10, "R6");
    step(0, 1, 24'hF0F0F0, 8'h00, 24'h202020, 8'h10, "R6");
    c_src = 3; c_pa = 8'hE0;
    step(1, 1, 24'h0F0F0F, 8'h01, 24'h808080, 8'hFF, "R6");

    // R7 premultiplied with saturation
    c_src = 0; c_pm = 1;
    step(1, 1, 24'hF0F0F0, 8'h20, 24'hF0F0F0, 8'hF0, "R7");
    step(0, 1, 24'h102030, 8'h80, 24'h405060, 8'h80, "R7");

    // R8 background replaces missing lower stage
    c_pm = 0; c_bc = 0; c_bg = 24'h3C5A78;
    step(1, 1, 24'hFF8800, 8'h60, 24'h111111, 8'h00, "R8");
    c_mode = 0;
    step(1, 1, 24'hFF8800, 8'h60, 24'h999999, 8'h12, "R8");
    c_bg = 24'h000000;
    step(0, 1, 24'hFF8800, 8'h60, 24'h999999, 8'h12, "R9");
    c_bc = 1;

    // R11 mixed patterns over all settings
    begin
      int unsigned seed = 32'h1234ABCD;
      for (int i = 0; i < 300; i++) begin
        bit fs, v;
        logic [23:0] tr, brr;
        logic [7:0] ta2, ba2;
        seed = seed * 1103515245 + 12345;
        fs = (seed[31:28] == 4'h0);
        v  = (seed[27:26] != 2'b00);
        c_mode = int'(seed[25:24]); c_src = int'(seed[23:22]); c_pm = int'(seed[21]);
        c_bc = int'(seed[20]); c_pa = int'(seed[19:12]); c_g = int'(seed[11:4]);
        seed = seed * 1103515245 + 12345;
        tr = seed[31:8]; ta2 = seed[7:0];
        seed = seed * 1103515245 + 12345;
        brr = seed[31:8]; ba2 = seed[7:0];
        c_bg = {seed[7:0], seed[15:8], seed[23:16]};
        step(fs, v, tr, ta2, brr, ba2, "R11");
      end
    end
    flush();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule